// File: doc/BRIEF.md
# Multi-Channel Column Overlap Engine

The block scores columns of a sparse-coding layer against a binary input pattern. Several channels run side by side. Each channel takes in one column record a word per beat. A record opens with three header words: two duty-cycle words that the block skips, then the column's boost factor. One permanence word per synapse follows the header. Synapse k of the record pairs with input bit k. A synapse scores when its permanence reaches the permanence threshold and its input bit is set. The channel counts these hits, then checks the raw count against a minimum-overlap threshold. A count that passes is scaled by the boost factor.

Channels that pass raise a request. A round-robin arbiter grants one request per transfer into a single output register, and tags the value with the column index and the channel number. A channel that has finished a record holds its stream ready low until its result is granted or dropped. This gives back-pressure from the output handshake to every stream. Loading a new input pattern also captures both thresholds and clears the work of every channel.

Top module: `ovl_accum_top`

## Requirements
- R1: A synapse word raises the raw count by one only if its value is greater than or equal to the captured permanence threshold and its input bit is 1.
- R2: In a record, beat 0 carries the column index on `ch_col`. Beats 0 and 1 are skipped, and beat 2 carries the boost factor in its low 16 bits. Beat 3+k is synapse k and pairs with `vec_bits[k]`. Synapses with k at or beyond the vector length never score.
- R3: A cycle with `vec_load` high does the following: it captures `vec_bits` and both thresholds, and clears every channel's count, bit pointer, record position and pending result. It also holds all `ch_ready` low and issues no grant.
- R4: The reported overlap is floor(raw × boost / 256), saturated at 2^OUT_W−1. The boost is unsigned with 8 integer and 8 fraction bits.
- R5: A boost word below 0x0100 is treated as exactly 0x0100 (unity).
- R6: A channel whose raw count is below the overlap threshold never requests and never appears on the output. Its `ch_ready` is high again two cycles after its last beat is accepted.
- R7: At most one `ch_gnt` bit is high per cycle, and only for a requesting channel. The transfer carries that channel's number on `out_ch` and the column index from its record.
- R8: Pending requests are served in round-robin order, starting from the channel after the one last granted. Channel 0 goes first after reset.
- R9: While `out_valid` is high and `out_ready` low, the output holds stable and no grant is issued. A channel with a pending result keeps `ch_ready` low.
- R10: With the output free, a qualifying result appears on `out_valid` two clock edges after its last beat is accepted. `ch_ready` stays low during the cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_load | input | 1 | Capture a new input pattern and thresholds, and clear the channels |
| vec_bits | input | IN_LEN | Binary input pattern |
| cfg_perm_th | input | WORD_W | Permanence threshold for a connected synapse |
| cfg_ovl_th | input | CNT_W | Minimum raw overlap |
| ch_valid | input | NUM_CH | Per-channel beat valid |
| ch_word | input | NUM_CH×WORD_W | Per-channel beat data |
| ch_last | input | NUM_CH | Last beat of the record |
| ch_col | input | NUM_CH×COL_W | Column index, sampled on beat 0 |
| ch_ready | output | NUM_CH | Channel accepts a beat |
| ch_gnt | output | NUM_CH | Grant acknowledgement |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_ovl | output | OUT_W | Boosted overlap |
| out_col | output | COL_W | Column index of the result |
| out_ch | output | CH_W | Source channel |

## Verification
Three things can land in the same cycle: a stalled output register (`out_ready` low), a channel finishing its record, and the other channels streaming beats. The random rounds cover this by dropping `out_ready` on about a third of cycles while all four channels stream records of random length with random gaps. Every held output cycle is compared with the previous one. Every transfer is matched against a bench-computed overlap, column and qualifying flag, and each qualifying column must appear exactly once. A separate directed case finishes four records on the same edge, then checks the order in which the queued requests are served.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int BOOST_W    = 16;
    localparam int BOOST_FRAC = 8;

    typedef logic [BOOST_W-1:0] boost_t;

    localparam boost_t BOOST_ONE = boost_t'(1) << BOOST_FRAC;

    // Position of the current beat within one column record.
    typedef enum logic [1:0] {
        SEG_DUTY_OV  = 2'd0,
        SEG_DUTY_ACT = 2'd1,
        SEG_BOOST    = 2'd2,
        SEG_SYN      = 2'd3
    } seg_phase_e;

    // Boost factors are never below unity.
    function automatic boost_t boost_floor(input boost_t b);
        return (b < BOOST_ONE) ? BOOST_ONE : b;
    endfunction

endpackage

// File: rtl/ovl_chan.sv
module ovl_chan
    import ovl_pkg::*;
#(
    parameter int IN_LEN = 64,
    parameter int WORD_W = 16,
    parameter int COL_W  = 8,
    parameter int OUT_W  = 12,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [IN_LEN-1:0] vec,
    input  logic [WORD_W-1:0] perm_th,
    input  logic [CNT_W-1:0]  ovl_th,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    input  logic [COL_W-1:0]  in_col,
    output logic              in_ready,
    output logic              req,
    output logic [OUT_W-1:0]  ovl,
    output logic [COL_W-1:0]  col,
    input  logic              gnt
);

    localparam int IDX_W  = (IN_LEN > 1) ? $clog2(IN_LEN) : 1;
    localparam int PROD_W = CNT_W + BOOST_W;
    localparam int SCL_W  = PROD_W - BOOST_FRAC;
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(IN_LEN);

    seg_phase_e         phase;
    logic [CNT_W-1:0]   ptr;
    logic [CNT_W-1:0]   acc;
    boost_t             boost;
    logic [COL_W-1:0]   col_q;
    logic               pend;
    logic               accept;
    logic               in_range;
    logic               syn_hit;
    logic               qual;
    logic [PROD_W-1:0]  prod;
    logic [SCL_W-1:0]   scaled;

    assign in_ready = !pend && !clr;
    assign accept   = in_valid && in_ready;
    assign in_range = (ptr < LEN_C);
    assign syn_hit  = (phase == SEG_SYN) && in_range &&
                      (in_word >= perm_th) && vec[ptr[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= SEG_DUTY_OV;
            ptr   <= '0;
            acc   <= '0;
            boost <= BOOST_ONE;
            col_q <= '0;
            pend  <= 1'b0;
        end else if (clr) begin
            phase <= SEG_DUTY_OV;
            ptr   <= '0;
            acc   <= '0;
            pend  <= 1'b0;
        end else begin
            if (pend && (gnt || !qual)) begin
                pend <= 1'b0;
            end
            if (accept) begin
                unique case (phase)
                    SEG_DUTY_OV: begin
                        col_q <= in_col;
                        acc   <= '0;
                        ptr   <= '0;
                        phase <= SEG_DUTY_ACT;
                    end
                    SEG_DUTY_ACT: phase <= SEG_BOOST;
                    SEG_BOOST: begin
                        boost <= boost_floor(in_word[BOOST_W-1:0]);
                        phase <= SEG_SYN;
                    end
                    default: begin
                        if (syn_hit) begin
                            acc <= acc + 1'b1;
                        end
                        if (in_range) begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                endcase
                if (in_last) begin
                    pend  <= 1'b1;
                    phase <= SEG_DUTY_OV;
                end
            end
        end
    end

    assign qual   = (acc >= ovl_th);
    assign req    = pend && qual;
    assign prod   = {{BOOST_W{1'b0}}, acc} * {{CNT_W{1'b0}}, boost};
    assign scaled = prod[PROD_W-1:BOOST_FRAC];
    assign col    = col_q;

    generate
        if (SCL_W > OUT_W) begin : g_sat
            assign ovl = (|scaled[SCL_W-1:OUT_W]) ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];
        end else begin : g_nosat
            assign ovl = OUT_W'(scaled);
        end
    endgenerate

endmodule

// File: rtl/ovl_rr_arb.sv
module ovl_rr_arb #(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [N-1:0]    req,
    output logic [N-1:0]    gnt,
    output logic [IDXW-1:0] gnt_idx
);

    logic [IDXW-1:0] last_q;
    logic            found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (en && !found && req[idx]) begin
                found        = 1'b1;
                gnt[idx]     = 1'b1;
                gnt_idx      = IDXW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDXW'(N - 1);
        end else if (found) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/ovl_accum_top.sv
module ovl_accum_top
    import ovl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IN_LEN = 64,
    parameter int WORD_W = 16,
    parameter int COL_W  = 8,
    parameter int OUT_W  = 12,
    parameter int CNT_W  = $clog2(IN_LEN + 1),
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vec_load,
    input  logic [IN_LEN-1:0]        vec_bits,
    input  logic [WORD_W-1:0]        cfg_perm_th,
    input  logic [CNT_W-1:0]         cfg_ovl_th,
    input  logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH*WORD_W-1:0] ch_word,
    input  logic [NUM_CH-1:0]        ch_last,
    input  logic [NUM_CH*COL_W-1:0]  ch_col,
    output logic [NUM_CH-1:0]        ch_ready,
    output logic [NUM_CH-1:0]        ch_gnt,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [OUT_W-1:0]         out_ovl,
    output logic [COL_W-1:0]         out_col,
    output logic [CH_W-1:0]          out_ch
);

    typedef struct packed {
        logic [OUT_W-1:0] ovl;
        logic [COL_W-1:0] col;
        logic [CH_W-1:0]  ch;
    } xfer_t;

    logic [IN_LEN-1:0] vec_q;
    logic [WORD_W-1:0] pth_q;
    logic [CNT_W-1:0]  oth_q;
    logic [NUM_CH-1:0] req_w;
    logic [NUM_CH-1:0] gnt_w;
    logic [OUT_W-1:0]  ovl_w [NUM_CH];
    logic [COL_W-1:0]  col_w [NUM_CH];
    logic [CH_W-1:0]   sel;
    logic              arb_en;
    xfer_t             out_q;
    logic              out_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            pth_q <= '0;
            oth_q <= '0;
        end else if (vec_load) begin
            vec_q <= vec_bits;
            pth_q <= cfg_perm_th;
            oth_q <= cfg_ovl_th;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            ovl_chan #(
                .IN_LEN (IN_LEN),
                .WORD_W (WORD_W),
                .COL_W  (COL_W),
                .OUT_W  (OUT_W),
                .CNT_W  (CNT_W)
            ) u_chan (
                .clk      (clk),
                .rst      (rst),
                .clr      (vec_load),
                .vec      (vec_q),
                .perm_th  (pth_q),
                .ovl_th   (oth_q),
                .in_valid (ch_valid[g]),
                .in_word  (ch_word[g*WORD_W +: WORD_W]),
                .in_last  (ch_last[g]),
                .in_col   (ch_col[g*COL_W +: COL_W]),
                .in_ready (ch_ready[g]),
                .req      (req_w[g]),
                .ovl      (ovl_w[g]),
                .col      (col_w[g]),
                .gnt      (gnt_w[g])
            );
        end
    endgenerate

    assign arb_en = (!out_v || out_ready) && !vec_load;

    ovl_rr_arb #(
        .N    (NUM_CH),
        .IDXW (CH_W)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .en      (arb_en),
        .req     (req_w),
        .gnt     (gnt_w),
        .gnt_idx (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else if (|gnt_w) begin
            out_v <= 1'b1;
            out_q <= '{ovl: ovl_w[sel], col: col_w[sel], ch: sel};
        end else if (out_ready) begin
            out_v <= 1'b0;
        end
    end

    assign ch_gnt    = gnt_w;
    assign out_valid = out_v;
    assign out_ovl   = out_q.ovl;
    assign out_col   = out_q.col;
    assign out_ch    = out_q.ch;

endmodule

// File: rtl/ovl_accum_chk.sv
module ovl_accum_chk #(
    parameter int NUM_CH = 4,
    parameter int OUT_W  = 12,
    parameter int COL_W  = 8,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              vec_load,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_gnt,
    input logic [NUM_CH-1:0] ch_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_ovl,
    input logic [COL_W-1:0]  out_col,
    input logic [CH_W-1:0]   out_ch
);

    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_gnt));

    // R7
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_gnt & ~ch_req) == '0);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_ovl) && $stable(out_col) && $stable(out_ch)));

    // R9
    no_gnt_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> (ch_gnt == '0));

    // R9
    req_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_req & ch_ready) == '0);

    // R10
    gnt_to_out_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_gnt) |=> out_valid);

    // R3
    load_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> (ch_gnt == '0 && ch_ready == '0));

endmodule

bind ovl_accum_top ovl_accum_chk #(
    .NUM_CH (NUM_CH),
    .OUT_W  (OUT_W),
    .COL_W  (COL_W),
    .CH_W   (CH_W)
) u_ovl_accum_chk (
    .clk       (clk),
    .rst       (rst),
    .vec_load  (vec_load),
    .ch_req    (req_w),
    .ch_gnt    (ch_gnt),
    .ch_ready  (ch_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ovl   (out_ovl),
    .out_col   (out_col),
    .out_ch    (out_ch)
);

// File: tb/test_ovl_accum_top.sv
module test_ovl_accum_top;

    localparam int NCH        = 4;
    localparam int IN_LEN     = 64;
    localparam int WORD_W     = 16;
    localparam int COL_W      = 8;
    localparam int OUT_W      = 12;
    localparam int CNT_W      = 7;
    localparam int CH_W       = 2;
    localparam int MAXB       = IN_LEN + 8;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;
    localparam int OUT_MAX    = (1 << OUT_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  vec_load = 1'b0;
    logic [IN_LEN-1:0]     vec_bits = '0;
    logic [WORD_W-1:0]     cfg_perm_th = '0;
    logic [CNT_W-1:0]      cfg_ovl_th = '0;
    logic [NCH-1:0]        ch_valid = '0;
    logic [NCH*WORD_W-1:0] ch_word = '0;
    logic [NCH-1:0]        ch_last = '0;
    logic [NCH*COL_W-1:0]  ch_col = '0;
    logic [NCH-1:0]        ch_ready;
    logic [NCH-1:0]        ch_gnt;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [OUT_W-1:0]      out_ovl;
    logic [COL_W-1:0]      out_col;
    logic [CH_W-1:0]       out_ch;

    ovl_accum_top #(
        .NUM_CH (NCH), .IN_LEN (IN_LEN), .WORD_W (WORD_W),
        .COL_W (COL_W), .OUT_W (OUT_W)
    ) i_ovl_accum_top (
        .clk (clk), .rst (rst), .vec_load (vec_load), .vec_bits (vec_bits),
        .cfg_perm_th (cfg_perm_th), .cfg_ovl_th (cfg_ovl_th),
        .ch_valid (ch_valid), .ch_word (ch_word), .ch_last (ch_last),
        .ch_col (ch_col), .ch_ready (ch_ready), .ch_gnt (ch_gnt),
        .out_valid (out_valid), .out_ready (out_ready), .out_ovl (out_ovl),
        .out_col (out_col), .out_ch (out_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [WORD_W-1:0] seg_w [NCH][MAXB];
    int                seg_len [NCH];
    logic [COL_W-1:0]  seg_col [NCH];
    int                exp_ovl [NCH];
    bit                exp_q [NCH];
    bit                seen [NCH];
    bit                act [NCH];
    int                cur [NCH];
    int                last_it [NCH];
    bit                take [NCH];
    logic [IN_LEN-1:0] cur_vec;
    logic [WORD_W-1:0] cur_pth;
    int                cur_oth;
    int                last_out_ch = NCH - 1;

    task automatic check(input bit ok, input string tag, input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Expected result of one channel from R1, R2, R4, R5.
    function automatic void model_ch(input int c);
        int raw = 0;
        longint b;
        longint p;
        for (int k = 3; k < seg_len[c]; k++) begin
            int j = k - 3;
            if (j < IN_LEN && seg_w[c][k] >= cur_pth && cur_vec[j]) raw++;
        end
        b = seg_w[c][2];
        if (b < 256) b = 256;
        p = (longint'(raw) * b) >> 8;
        if (p > OUT_MAX) p = OUT_MAX;
        exp_ovl[c] = int'(p);
        exp_q[c]   = (raw >= cur_oth);
    endfunction

    task automatic build_seg(input int c, input int col, input int boost, input int nsyn, input int pmode);
        seg_len[c] = 3 + nsyn;
        seg_col[c] = COL_W'(col);
        seg_w[c][0] = WORD_W'($urandom);
        seg_w[c][1] = WORD_W'($urandom);
        seg_w[c][2] = WORD_W'(boost);
        for (int k = 3; k < seg_len[c]; k++) begin
            seg_w[c][k] = (pmode == 1) ? '1 : WORD_W'($urandom);
        end
        act[c] = 1;
    endtask

    task automatic load_vec(input logic [IN_LEN-1:0] v, input logic [WORD_W-1:0] pth, input int oth);
        @(negedge clk);
        vec_load    = 1'b1;
        vec_bits    = v;
        cfg_perm_th = pth;
        cfg_ovl_th  = CNT_W'(oth);
        cur_vec     = v;
        cur_pth     = pth;
        cur_oth     = oth;
        #1;
        check(ch_ready == '0, "R3 ready low during load", ch_ready, 0);
        @(posedge clk);
        @(negedge clk);
        vec_load = 1'b0;
        for (int c = 0; c < NCH; c++) act[c] = 0;
    endtask

    task automatic run_round(input bit gaps, input bit rnd_rdy, input bit lat_mode, input bit rr_mode);
        int it = 0;
        int idle = 0;
        int first_v = -1;
        bit hold = 0;
        bit work;
        bit rdy;
        logic [OUT_W-1:0] h_ovl;
        logic [COL_W-1:0] h_col;
        logic [CH_W-1:0]  h_ch;
        for (int c = 0; c < NCH; c++) begin
            cur[c] = 0; seen[c] = 0; last_it[c] = -1;
            if (act[c]) model_ch(c);
        end
        while (idle < 6) begin
            @(negedge clk);
            if (hold) begin
                check(out_valid && out_ovl == h_ovl && out_col == h_col && out_ch == h_ch,
                      "R9 output held under stall", out_ovl, h_ovl);
                hold = 0;
            end
            if (out_valid && first_v < 0) first_v = it;
            if (lat_mode) begin
                for (int c = 0; c < NCH; c++) begin
                    if (act[c] && last_it[c] >= 0 && it == last_it[c] + 1)
                        check(ch_ready[c] == 1'b0, "R10 stalled after last beat", ch_ready[c], 0);
                    if (act[c] && last_it[c] >= 0 && it == last_it[c] + 2)
                        check(ch_ready[c] == 1'b1, "R6 ready again", ch_ready[c], 1);
                end
            end
            rdy = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
            out_ready = rdy;
            if (out_valid && rdy) begin
                int oc = int'(out_ch);
                check(exp_q[oc] && act[oc] && !seen[oc], "R6 R7 transfer from qualifying channel", oc, oc);
                check(out_col == seg_col[oc], "R7 column tag", out_col, seg_col[oc]);
                check(int'(out_ovl) == exp_ovl[oc], "R1 R2 R4 R5 overlap", out_ovl, exp_ovl[oc]);
                if (rr_mode)
                    check(oc == (last_out_ch + 1) % NCH, "R8 round-robin order", oc, (last_out_ch + 1) % NCH);
                last_out_ch = oc;
                seen[oc] = 1;
            end else if (out_valid) begin
                hold = 1; h_ovl = out_ovl; h_col = out_col; h_ch = out_ch;
            end
            work = 0;
            for (int c = 0; c < NCH; c++) begin
                take[c] = 0;
                if (act[c] && cur[c] < seg_len[c]) work = 1;
                if (act[c] && cur[c] < seg_len[c] && (!gaps || $urandom % 4 != 0)) begin
                    ch_valid[c] = 1'b1;
                    ch_word[c*WORD_W +: WORD_W] = seg_w[c][cur[c]];
                    ch_last[c] = (cur[c] == seg_len[c] - 1);
                    ch_col[c*COL_W +: COL_W] = seg_col[c];
                    take[c] = ch_ready[c];
                end else begin
                    ch_valid[c] = 1'b0;
                    ch_last[c] = 1'b0;
                end
            end
            if (!work && !out_valid) idle++; else idle = 0;
            @(posedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (take[c]) begin
                    if (cur[c] == seg_len[c] - 1) last_it[c] = it;
                    cur[c]++;
                end
            end
            it++;
        end
        ch_valid = '0;
        ch_last = '0;
        for (int c = 0; c < NCH; c++) begin
            if (act[c]) check(seen[c] == exp_q[c], "R6 channel reported iff qualifying", seen[c], exp_q[c]);
        end
        if (lat_mode && exp_q[0])
            check(first_v == last_it[0] + 2, "R10 output latency", first_v, last_it[0] + 2);
    endtask

    initial begin
        logic [IN_LEN-1:0] v;
        process::self().srandom(32'd12345);
        for (int c = 0; c < NCH; c++) act[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 no output after reset", out_valid, 0);
        check(ch_ready == '1, "R3 channels ready after reset", ch_ready, 15);
        check(ch_gnt == '0, "R7 no grant after reset", ch_gnt, 0);

        // R1: alternating input bits, mixed permanences around threshold
        load_vec({(IN_LEN/2){2'b10}}, 16'h8000, 0);
        build_seg(0, 17, 16'h0100, 40, 0);
        for (int k = 3; k < seg_len[0]; k++) seg_w[0][k] = (k % 3 == 0) ? 16'h8000 : 16'h7FFF;
        run_round(0, 0, 0, 0);

        // R2: record longer than the vector, all connected
        load_vec('1, 16'h0001, 0);
        build_seg(1, 33, 16'h0100, IN_LEN + 5, 1);
        run_round(0, 0, 0, 0);

        // R5: boost below unity
        load_vec('1, 16'h0001, 0);
        build_seg(2, 5, 16'h0040, 20, 1);
        run_round(0, 0, 0, 0);

        // R4: saturation
        load_vec('1, 16'h0001, 0);
        build_seg(3, 99, 16'hFFFF, IN_LEN, 1);
        run_round(0, 0, 0, 0);

        // R6: below threshold, latency view
        load_vec('1, 16'h0001, 50);
        build_seg(0, 7, 16'h0200, 10, 1);
        run_round(0, 0, 1, 0);

        // R10: qualifying, latency view
        load_vec('1, 16'h0001, 3);
        build_seg(0, 8, 16'h0180, 10, 1);
        run_round(0, 0, 1, 0);

        // R8: all channels finish together
        load_vec('1, 16'h0001, 0);
        for (int c = 0; c < NCH; c++) build_seg(c, 40 + c, 16'h0100 + c, 12, 1);
        run_round(0, 0, 0, 1);

        // R3: abandon a partial record with a new load
        load_vec('1, 16'h0000, 0);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            ch_valid[0] = 1'b1;
            ch_word[0 +: WORD_W] = 16'hFFFF;
            ch_last[0] = 1'b0;
            @(negedge clk);
        end
        ch_valid[0] = 1'b0;
        v = {(IN_LEN/4){4'b0011}};
        load_vec(v, 16'h4000, 2);
        build_seg(0, 61, 16'h0100, 30, 0);
        run_round(0, 0, 0, 0);

        // Random rounds with stalls and gaps
        for (int r = 0; r < 25; r++) begin
            v = {$urandom, $urandom};
            load_vec(v, WORD_W'($urandom), int'($urandom % 24));
            for (int c = 0; c < NCH; c++) begin
                int bsel = int'($urandom % 4);
                int bst  = (bsel == 0) ? int'($urandom % 256) :
                           (bsel == 1) ? int'($urandom % 65536) : 256 + int'($urandom % 512);
                if ($urandom % 5 != 0)
                    build_seg(c, int'($urandom % 256), bst, int'($urandom % (IN_LEN + 5)), 0);
            end
            run_round(1, 1, 0, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule